// File: doc/BRIEF.md
# NAND Flash Micro-Opcode Sequencer

This block drives one 8-bit NAND flash device. It does not contain fixed read, program or erase engines. It steps through a short program of 4-bit micro-opcodes held in an instruction register. Each opcode does one thing:

- emit a command byte taken from a command register;
- emit column, row or user address cycles;
- move data between an internal page buffer and the device;
- wait for the ready line;
- fetch a status byte.

Software builds an operation from these steps. A page read is command, column, row, command, wait-and-read. A page program is command, column, row, write, command, wait, status.

The host loads the configuration registers through a simple register port. It fills or drains the page buffer through a separate byte port, and starts a program by writing the launch address. Each flash bus cycle lasts two clocks: the strobe is low in the first clock and high in the second. Write data is held across both clocks, and read data is sampled at the end of the low clock. Every ready wait is bounded by a programmable timeout. The block ends with either a completion flag or an error flag.

Top module: `nand_opseq`

## Requirements
- R1: After reset the chip enable, write strobe and read strobe outputs are high, the command and address latch outputs are low, the data bus is not driven, and both the completion and error flags are low. The timeout field reads back as 15 at register address 6, bits 7:4.
- R2: The instruction register holds eight 4-bit slots, slot 0 in bits 31:28 down to slot 7 in bits 3:0, and they run in slot order. Opcode encoding: 1-4 command slots 0-3, 5 column, 6 row, 7 user address, 8 wait-then-read, 9 write, 10 wait, 11 status. Opcode 0 (and 12-15) ends the program: later slots are ignored, chip enable returns high and completion is set.
- R3: A command opcode n emits one write cycle with CLE high and ALE low, carrying command byte n, where byte 0 is bits 31:24 and byte 3 is bits 7:0 of the command register (address 1).
- R4: The column opcode emits ALE cycles. In large-page mode (mode bit 0 = 1) it emits two cycles, low byte first, of the column plus 128 when the spare flag is set. In small-page mode it emits one cycle carrying column bits 7:0.
- R5: The row opcode emits 2 + AL ALE cycles (AL = mode bits 2:1, 0 to 2), least significant byte first, of the page number. The page number is {block, index[5:0]} in large-page mode and {block, index[4:0]} in small-page mode. Block is at register address 2. The page register (address 3) holds column in bits 11:0, spare flag in bit 12 and index in bits 21:16.
- R6: The user-address opcode emits one ALE cycle carrying bits 7:0 of the data register (address 5).
- R7: A byte count (address 4, bits 15:0) of zero transfers one page plus spare, 144 bytes large or 40 bytes small. A nonzero count transfers exactly that many bytes, leaving the next buffer byte untouched.
- R8: Buffer transfers start at region × 64 + column, plus the page size (128 large, 32 small) when the spare flag is set, modulo 512. The region is (page & 1) × 4 in large-page mode and (page & 7) in small-page mode.
- R9: The wait-then-read opcode waits for R/B# high and then stores the device bytes into the buffer in order. The write opcode emits buffer bytes in order with CLE and ALE low.
- R10: The status opcode reads one byte into data register bits 7:0. The wait opcode holds the program until R/B# is high.
- R11: A ready wait that lasts past (T + 1) × 16 cycles, where T is mode bits 7:4, aborts the program. The error flag is set, completion stays clear and chip enable returns high.
- R12: Writing register address 7 while idle launches the program and clears both flags. Completion is set only on a normal end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe (honoured while idle) |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (address 7: {err, done}) |
| buf_we | input | 1 | Host buffer byte write (honoured while idle) |
| buf_addr | input | AW | Host buffer byte address |
| buf_wdata | input | 8 | Host buffer write byte |
| buf_rdata | output | 8 | Host buffer read byte |
| busy | output | 1 | Program running |
| done | output | 1 | Completion flag |
| err | output | 1 | Timeout error flag |
| ce_n | output | 1 | Chip enable, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Write strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| dq_o | output | 8 | Flash data out |
| dq_oe | output | 1 | Flash data output enable |
| dq_i | input | 8 | Flash data in |
| rb_n | input | 1 | Ready/busy from device, low = busy |

## Verification
A read-style program is swept over both page sizes, all three row-cycle lengths and both spare-flag settings. Changing block, index and column values separate the 5-bit and 6-bit page splits, the region choice and the spare offset in both the emitted address bytes and the buffer landing position. Byte counts of zero and five separate the full-page case from exact-length transfers, and the byte just past each transfer shows overruns. Separate write, user-address, early-end and timeout programs cover buffer-to-device order, status capture, ignored slots and the bound on ready waits at two timeout settings.

// File: rtl/nand_opseq.sv
module nand_opseq #(
  parameter int REGION   = 64,
  parameter int SP_PAGE  = 32,
  parameter int SP_SPARE = 8,
  parameter int LP_PAGE  = 128,
  parameter int LP_SPARE = 16,
  parameter int TO_UNIT  = 16,
  parameter int SETTLE   = 2,
  parameter int AW       = $clog2(8*REGION)
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          buf_we,
  input  logic [AW-1:0] buf_addr,
  input  logic [7:0]    buf_wdata,
  output logic [7:0]    buf_rdata,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic          ce_n,
  output logic          cle,
  output logic          ale,
  output logic          we_n,
  output logic          re_n,
  output logic [7:0]    dq_o,
  output logic          dq_oe,
  input  logic [7:0]    dq_i,
  input  logic          rb_n
);
  localparam int DEPTH = 8*REGION;
  localparam logic [3:0] OP_CM0 = 4'd1, OP_CM3 = 4'd4, OP_CA = 4'd5, OP_PA = 4'd6,
                         OP_UA = 4'd7, OP_RBW = 4'd8, OP_WB = 4'd9, OP_CW1 = 4'd10,
                         OP_RS = 4'd11;

  typedef enum logic [2:0] {S_IDLE, S_DEC, S_LO, S_HI, S_WAIT} st_t;
  st_t state;

  logic [31:0]   instr, cmd;
  logic [26:0]   blk;
  logic [11:0]   col;
  logic          spare, lp, done_q, err_q;
  logic [5:0]    pidx;
  logic [15:0]   cnt, k, n, wcnt;
  logic [7:0]    dat;
  logic [1:0]    al;
  logic [3:0]    cwto, op;
  logic [2:0]    slot;
  logic [AW-1:0] ptr;
  logic [7:0]    mem [0:DEPTH-1];

  logic [31:0]   pnum;
  logic [15:0]   page_sz, start_off, xfer, limit;
  logic [2:0]    region;
  logic [AW-1:0] base;
  logic [3:0]    cur_op;
  logic [1:0]    cj;
  logic          is_rd, bus, last;
  logic [7:0]    bus_byte;

  assign pnum      = lp ? {blk[25:0], pidx} : {blk, pidx[4:0]};
  assign page_sz   = lp ? 16'(LP_PAGE) : 16'(SP_PAGE);
  assign start_off = {4'b0, col} + (spare ? page_sz : 16'd0);
  assign xfer      = (cnt == 16'd0) ? page_sz + (lp ? 16'(LP_SPARE) : 16'(SP_SPARE)) : cnt;
  assign region    = lp ? {pnum[0], 2'b00} : pnum[2:0];
  assign base      = AW'(32'(region) * REGION) + AW'(start_off);
  assign limit     = 16'((32'(cwto) + 1) * TO_UNIT);
  assign cur_op    = instr[{~slot, 2'b00} +: 4];
  assign cj        = op[1:0] - 2'd1;
  assign is_rd     = (op == OP_RBW) || (op == OP_RS);
  assign bus       = (state == S_LO) || (state == S_HI);
  assign last      = (slot == 3'd7);

  always_comb begin
    bus_byte = 8'h00;
    if (op >= OP_CM0 && op <= OP_CM3) bus_byte = cmd[{~cj, 3'b000} +: 8];
    else if (op == OP_CA)  bus_byte = lp ? ((k == 16'd0) ? start_off[7:0] : start_off[15:8]) : col[7:0];
    else if (op == OP_PA)  bus_byte = pnum[{k[1:0], 3'b000} +: 8];
    else if (op == OP_UA)  bus_byte = dat;
    else if (op == OP_WB)  bus_byte = mem[ptr];
  end

  assign busy  = (state != S_IDLE);
  assign ce_n  = (state == S_IDLE);
  assign cle   = bus && (op >= OP_CM0) && (op <= OP_CM3);
  assign ale   = bus && ((op == OP_CA) || (op == OP_PA) || (op == OP_UA));
  assign we_n  = !((state == S_LO) && !is_rd);
  assign re_n  = !((state == S_LO) && is_rd);
  assign dq_oe = bus && !is_rd;
  assign dq_o  = bus_byte;
  assign done  = done_q;
  assign err   = err_q;
  assign buf_rdata = mem[buf_addr];

  always_comb
    case (reg_addr)
      3'd0: reg_rdata = instr;
      3'd1: reg_rdata = cmd;
      3'd2: reg_rdata = {5'b0, blk};
      3'd3: reg_rdata = {10'b0, pidx, 3'b0, spare, col};
      3'd4: reg_rdata = {16'b0, cnt};
      3'd5: reg_rdata = {24'b0, dat};
      3'd6: reg_rdata = {24'b0, cwto, 1'b0, al, lp};
      default: reg_rdata = {30'b0, err_q, done_q};
    endcase

  always_ff @(posedge clk)
    if (state == S_LO && op == OP_RBW) mem[ptr] <= dq_i;
    else if (buf_we && state == S_IDLE) mem[buf_addr] <= buf_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_IDLE; instr <= '0; cmd <= '0; blk <= '0; col <= '0; spare <= 1'b0;
      pidx <= '0; cnt <= '0; dat <= '0; lp <= 1'b0; al <= '0; cwto <= 4'hF;
      done_q <= 1'b0; err_q <= 1'b0; slot <= '0; op <= '0; k <= '0; n <= '0;
      ptr <= '0; wcnt <= '0;
    end else
      case (state)
        S_IDLE:
          if (reg_we)
            case (reg_addr)
              3'd0: instr <= reg_wdata;
              3'd1: cmd <= reg_wdata;
              3'd2: blk <= reg_wdata[26:0];
              3'd3: begin col <= reg_wdata[11:0]; spare <= reg_wdata[12]; pidx <= reg_wdata[21:16]; end
              3'd4: cnt <= reg_wdata[15:0];
              3'd5: dat <= reg_wdata[7:0];
              3'd6: begin lp <= reg_wdata[0]; al <= reg_wdata[2:1]; cwto <= reg_wdata[7:4]; end
              default: begin state <= S_DEC; slot <= '0; done_q <= 1'b0; err_q <= 1'b0; ptr <= base; end
            endcase
        S_DEC: begin
          op <= cur_op; k <= '0; wcnt <= '0;
          case (cur_op)
            4'd1, 4'd2, 4'd3, 4'd4, OP_UA, OP_RS: begin n <= 16'd1; state <= S_LO; end
            OP_CA:  begin n <= lp ? 16'd2 : 16'd1; state <= S_LO; end
            OP_PA:  begin n <= 16'(al) + 16'd2; state <= S_LO; end
            OP_WB:  begin n <= xfer; state <= S_LO; end
            OP_RBW: begin n <= xfer; state <= S_WAIT; end
            OP_CW1: state <= S_WAIT;
            default: begin state <= S_IDLE; done_q <= 1'b1; end
          endcase
        end
        S_LO: begin
          if (op == OP_RS) dat <= dq_i;
          state <= S_HI;
        end
        S_HI: begin
          if (op == OP_RBW || op == OP_WB) ptr <= ptr + 1'b1;
          if (k == n - 16'd1) begin
            if (last) begin state <= S_IDLE; done_q <= 1'b1; end
            else begin slot <= slot + 3'd1; state <= S_DEC; end
          end else begin
            k <= k + 16'd1; state <= S_LO;
          end
        end
        default: begin
          wcnt <= wcnt + 16'd1;
          if (wcnt >= 16'(SETTLE) && rb_n) begin
            if (op == OP_RBW) state <= S_LO;
            else if (last) begin state <= S_IDLE; done_q <= 1'b1; end
            else begin slot <= slot + 3'd1; state <= S_DEC; end
          end else if (wcnt >= limit) begin
            err_q <= 1'b1; state <= S_IDLE;
          end
        end
      endcase

  // R11
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(err) |-> ce_n);
  // R12
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(done && err));
  // R2
  end_flag_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(ce_n) |-> (done || err));
  // R3
  latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(cle && ale));
  // R9
  read_bus_chk: assert property (@(posedge clk) disable iff (!rst_n) !re_n |-> !dq_oe);
  // R12
  launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
                               (reg_we && reg_addr == 3'd7 && ce_n) |=> !ce_n);
endmodule

// File: tb/test_nand_opseq.sv
module test_nand_opseq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0, buf_we = 1'b0, rb_n = 1'b1;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [8:0] buf_addr = '0;
  logic [7:0] buf_wdata = '0, buf_rdata, dq_o, dq_i;
  logic busy, done, err, ce_n, cle, ale, we_n, re_n, dq_oe;

  int n_chk = 0, n_fail = 0, rd_cnt = 0, ev_cnt = 0;
  bit ev_c [0:63];
  bit ev_a [0:63];
  int ev_d [0:63];
  bit finished = 0;

  always #4 clk = ~clk;

  nand_opseq i_nand_opseq (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .buf_we(buf_we), .buf_addr(buf_addr),
    .buf_wdata(buf_wdata), .buf_rdata(buf_rdata), .busy(busy), .done(done), .err(err),
    .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n), .re_n(re_n), .dq_o(dq_o), .dq_oe(dq_oe),
    .dq_i(dq_i), .rb_n(rb_n));

  assign dq_i = 8'((rd_cnt * 7 + 3) & 255);
  always @(posedge re_n) if (!ce_n) rd_cnt = rd_cnt + 1;
  always @(posedge we_n)
    if (!ce_n) begin
      if (ev_cnt < 64) begin ev_c[ev_cnt] = cle; ev_a[ev_cnt] = ale; ev_d[ev_cnt] = int'(dq_o); end
      ev_cnt = ev_cnt + 1;
    end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic fill(input bit pat);
    for (int i = 0; i < 512; i++) begin
      @(negedge clk); buf_we = 1'b1; buf_addr = 9'(i);
      buf_wdata = pat ? 8'(i ^ 8'h5A) : 8'hEE;
    end
    @(negedge clk); buf_we = 1'b0;
  endtask

  task automatic rdbuf(input int a, output int v);
    @(negedge clk); buf_addr = 9'(a % 512); #1; v = int'(buf_rdata);
  endtask

  task automatic run(input int rbdly, output int cyc);
    rd_cnt = 0; ev_cnt = 0; rb_n = 1'b0;
    wr(7, 32'h0);
    cyc = 0;
    for (int c = 0; c < 5000; c++) begin
      @(negedge clk);
      if (c == rbdly) rb_n = 1'b1;
      cyc = c;
      if (!busy) break;
    end
    rb_n = 1'b1;
  endtask

  task automatic ev(input int i, input bit c, input bit a, input int d, input string req);
    chk(ev_c[i] == c && ev_a[i] == a && ev_d[i] == d, req, ev_d[i], d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL R12 watchdog actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int cyc, v, e, idx, sp, blkv, colv, cntv, pnum, nc, co, xf, base, full, t1, t2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(ce_n && we_n && re_n && !cle && !ale && !dq_oe, "R1 pins", {ce_n, we_n, re_n, cle, ale, dq_oe}, 6'b111000);
    chk(!done && !err, "R1 flags", {done, err}, 0);
    reg_addr = 3'd6; #1;
    chk(reg_rdata[7:4] == 4'hF, "R1 timeout field", int'(reg_rdata[7:4]), 15);

    // Read sweep: R3 R4 R5 R7 R8 R9
    for (int lpv = 0; lpv < 2; lpv++)
      for (int alv = 0; alv < 3; alv++)
        for (int spv = 0; spv < 2; spv++) begin
          int it;
          it = lpv * 6 + alv * 2 + spv;
          sp = spv;
          fill(1'b0);
          idx = (37 + it) & 63; blkv = 32'h1234 + it * 273; colv = it;
          cntv = (it % 3 == 0) ? 0 : 5;
          wr(6, 32'(8'hF0 | (alv << 1) | lpv));
          wr(2, 32'(blkv)); wr(3, 32'((idx << 16) | (sp << 12) | colv));
          wr(4, 32'(cntv)); wr(0, 32'h15628000); wr(1, 32'h0030A55A);
          run(5, cyc);
          pnum = lpv ? ((blkv << 6) | (idx & 63)) : ((blkv << 5) | (idx & 31));
          nc = lpv ? 2 : 1;
          co = lpv ? colv + (sp ? 128 : 0) : colv;
          chk(ev_cnt == 2 + nc + 2 + alv, "R5 event count", ev_cnt, 4 + nc + alv);
          ev(0, 1, 0, 8'h00, "R3 cmd0");
          for (int b = 0; b < nc; b++) ev(1 + b, 0, 1, (co >> (8 * b)) & 255, "R4 column");
          for (int b = 0; b < 2 + alv; b++) ev(1 + nc + b, 0, 1, (pnum >> (8 * b)) & 255, "R5 row");
          ev(3 + nc + alv, 1, 0, 8'h30, "R3 cmd1");
          full = lpv ? 144 : 40;
          xf = (cntv == 0) ? full : cntv;
          base = ((lpv ? (pnum & 1) * 4 : (pnum & 7)) * 64 + (sp ? (lpv ? 128 : 32) : 0) + colv) % 512;
          rdbuf(base, v);
          chk(v == 3, "R8 first byte", v, 3);
          rdbuf(base + xf - 1, v);
          e = ((xf - 1) * 7 + 3) & 255;
          chk(v == e, "R7 last byte", v, e);
          rdbuf(base + xf, v);
          chk(v == 8'hEE, "R7 no overrun", v, 8'hEE);
          chk(done && !err, "R9 done", {done, err}, 2);
        end

    // Write program: R9 R10
    fill(1'b1);
    wr(6, 32'hF1); wr(2, 32'd2); wr(3, 32'((3 << 16) | 4)); wr(4, 32'd6);
    wr(0, 32'h35694AB0); wr(1, 32'h00008010);
    run(30, cyc);
    chk(ev_cnt == 12, "R9 write event count", ev_cnt, 12);
    ev(0, 1, 0, 8'h80, "R3 cmd2");
    ev(1, 0, 1, 4, "R4 column lo"); ev(2, 0, 1, 0, "R4 column hi");
    ev(3, 0, 1, 131, "R5 row0"); ev(4, 0, 1, 0, "R5 row1");
    for (int j = 0; j < 6; j++) ev(5 + j, 0, 0, ((260 + j) ^ 8'h5A) & 255, "R9 write data");
    ev(11, 1, 0, 8'h10, "R3 cmd3");
    reg_addr = 3'd5; #1;
    chk(reg_rdata[7:0] == 8'h03, "R10 status byte", int'(reg_rdata[7:0]), 3);
    chk(done && !err, "R10 wait done", {done, err}, 2);

    // User address: R6
    fill(1'b0);
    wr(6, 32'hF0); wr(2, 0); wr(3, 0); wr(4, 3); wr(5, 32'h5A);
    wr(0, 32'h17800000); wr(1, 32'h90000000);
    run(4, cyc);
    chk(ev_cnt == 2, "R6 event count", ev_cnt, 2);
    ev(0, 1, 0, 8'h90, "R3 cmd0 ua");
    ev(1, 0, 1, 8'h5A, "R6 user byte");
    rdbuf(2, v); chk(v == 17, "R9 third read byte", v, 17);
    rdbuf(3, v); chk(v == 8'hEE, "R7 exact count", v, 8'hEE);

    // Early end: R2
    wr(0, 32'h10200000); wr(1, 32'h11223344);
    run(0, cyc);
    chk(ev_cnt == 1, "R2 slots after end ignored", ev_cnt, 1);
    ev(0, 1, 0, 8'h11, "R2 slot0 ran");
    chk(ce_n && done && !err, "R2 idle after end", {ce_n, done, err}, 6);

    // Timeout: R11
    wr(6, 32'h00); wr(0, 32'hA0000000);
    run(-1, t1);
    chk(err && !done && ce_n, "R11 flags", {err, done, ce_n}, 5);
    chk(t1 >= 16 && t1 <= 18, "R11 window T0", t1, 17);
    wr(6, 32'h30);
    run(-1, t2);
    chk(err && !done, "R11 flags T3", {err, done}, 2);
    chk(t2 >= 64 && t2 <= 66, "R11 window T3", t2, 65);

    // Relaunch clears error: R12
    wr(6, 32'hF0); wr(0, 32'h10000000);
    run(0, cyc);
    chk(done && !err, "R12 relaunch", {done, err}, 2);
    reg_addr = 3'd7; #1;
    chk(reg_rdata[1:0] == 2'b01, "R12 status reg", int'(reg_rdata[1:0]), 1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule